// File: doc/BRIEF.md
# Unlockable Program Memory Write Port

A small memory-mapped peripheral for a processor whose instruction memory sits in a separate address space from its data memory. The processor writes the words of a program image through this port. The port passes each word to the instruction memory's write interface, but only after a 32-bit key has opened it.

Three word-aligned registers sit on a simple single-cycle write bus. The key register opens or closes the port. The target register holds the byte address of the next program word. The data register, while the port is open, sends one 32-bit word to instruction memory and then moves the target on by one word. The next write therefore lands at the following location without the address being reloaded.

Top module: `progmem_write_port`

## Requirements
- R1: A synchronous active-low reset closes the port, clears the target address to 0 and holds `pm_wr_en` low in the cycle after the reset edge. A data write that follows a reset is dropped until the key is written again.
- R2: A key-register write (offset select 0) whose data is exactly 0x1337F7D1 opens the port.
- R3: A key-register write with any other value closes the port, even if the port was open. Values that differ from the key by a single bit are included.
- R4: A target-register write (offset select 1) loads all 32 bits of `bus_wdata` as the target byte address.
- R5: A data-register write (offset select 2) while the port is open raises `pm_wr_en` for exactly one cycle, starting at the clock edge that accepts it. During that cycle `pm_wr_addr` is target[31:2] and `pm_wr_data` is the written word.
- R6: A data-register write while the port is closed produces no `pm_wr_en` pulse and leaves the target address unchanged.
- R7: Each accepted data write advances the target by 4, modulo 2^32, so 0xFFFFFFFC wraps to 0.
- R8: Target address bits [1:0] never reach instruction memory. Only target[31:2] is output, and the advance by 4 leaves those two bits unchanged.
- R9: A bus cycle with `bus_valid` low, or with `bus_write` low, or with offset select 3 changes no state and raises no strobe.
- R10: The register is chosen by `bus_addr[3:2]` alone. `bus_addr[1:0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_write | input | 1 | Bus cycle is a write |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Bus write data |
| pm_wr_en | output | 1 | One-cycle instruction memory write strobe |
| pm_wr_addr | output | 30 | Instruction memory word address |
| pm_wr_data | output | 32 | Instruction memory write word |

## Verification
Directed sequences cover several cases. A burst of data writes after one unlock shows that the address advances. Data writes after a wrong key, and after a reset, show that a closed port drops writes without moving the target. A target load near the top of the space checks the wrap. Loads with nonzero low bits check that bits [1:0] are masked. Separate cycles drive low `bus_valid`, low `bus_write`, offset 3 and low offset bits on a data select, to show that decode depends only on bits [3:2] and the write qualifiers. A long pseudo-random mix of key values, targets, data writes and idle cycles then runs against a behavioural model on every clock, so that ordering effects the directed cases miss are also covered.

// File: rtl/pmwp_pkg.sv
// Package: shared constants and the register select encoding for the
// program memory write port. Assumes a 4-bit byte offset bus.
package pmwp_pkg;
    localparam logic [31:0] UNLOCK_KEY = 32'h1337_F7D1;
    localparam int          OFFS_W     = 4;

    typedef enum logic [1:0] {
        SEL_KEY    = 2'd0,
        SEL_TARGET = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pmwp_decode.sv
// Register decode: turns one bus cycle into at most one of three write
// strobes. Assumes single-cycle acceptance; uses bus_addr[3:2] only.
module pmwp_decode
    import pmwp_pkg::*;
(
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [OFFS_W-1:0] bus_addr,
    output logic              key_wr,
    output logic              target_wr,
    output logic              data_wr
);
    reg_sel_e sel;

    // Pick the register from the word-select bits.
    always_comb begin
        sel       = reg_sel_e'(bus_addr[3:2]);
        key_wr    = 1'b0;
        target_wr = 1'b0;
        data_wr   = 1'b0;
        if (bus_valid && bus_write) begin
            case (sel)
                SEL_KEY:    key_wr    = 1'b1;
                SEL_TARGET: target_wr = 1'b1;
                SEL_DATA:   data_wr   = 1'b1;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/pmwp_key_guard.sv
// Key guard: holds the open/closed state. Every key write re-evaluates
// it, so only an exact match leaves the port open. Sync active-low reset.
module pmwp_key_guard
    import pmwp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              is_open
);
    // Compare the written value with the key on every key write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            is_open <= 1'b0;
        else if (key_wr)
            is_open <= (key_val == DATA_W'(UNLOCK_KEY));
    end
endmodule

// File: rtl/pmwp_addr_ptr.sv
// Target address pointer: loaded whole by software and advanced by one
// word per accepted write. Load and advance never coincide.
module pmwp_addr_ptr #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              advance,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Load or step the pointer; wraps modulo 2^ADDR_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (advance)
            ptr <= ptr + STEP_V;
    end
endmodule

// File: rtl/progmem_write_port.sv
// Program memory write port top: decode, key guard and pointer, plus the
// registered write issue toward instruction memory. Outputs are registered;
// pm_wr_addr/pm_wr_data are meaningful only while pm_wr_en is high.
module progmem_write_port
    import pmwp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [OFFS_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic                      pm_wr_en,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] pm_wr_addr,
    output logic [DATA_W-1:0]         pm_wr_data
);
    localparam int WORD_LSB = $clog2(DATA_W/8);
    localparam int STEP     = DATA_W/8;

    logic              key_wr, target_wr, data_wr;
    logic              port_open;
    logic              accept;
    logic [ADDR_W-1:0] tgt_addr;

    pmwp_decode u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .key_wr    (key_wr),
        .target_wr (target_wr),
        .data_wr   (data_wr)
    );

    pmwp_key_guard #(.DATA_W(DATA_W)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_val (bus_wdata),
        .is_open (port_open)
    );

    // A data write goes through only while the port is open.
    assign accept = data_wr && port_open;

    pmwp_addr_ptr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (target_wr),
        .load_val (bus_wdata[ADDR_W-1:0]),
        .advance  (accept),
        .ptr      (tgt_addr)
    );

    // Register the write toward instruction memory, one cycle per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_wr_en   <= 1'b0;
            pm_wr_addr <= '0;
            pm_wr_data <= '0;
        end else begin
            pm_wr_en <= accept;
            if (accept) begin
                pm_wr_addr <= tgt_addr[ADDR_W-1:WORD_LSB];
                pm_wr_data <= bus_wdata;
            end
        end
    end
endmodule

// File: rtl/progmem_write_port_chk.sv
// Checker for the program memory write port, bound to the top module.
module progmem_write_port_chk
    import pmwp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [OFFS_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              pm_wr_en,
    input logic              port_open,
    input logic [ADDR_W-1:0] tgt_addr
);
    logic key_cyc, tgt_cyc, dat_cyc;
    assign key_cyc = bus_valid && bus_write && bus_addr[3:2] == 2'd0;
    assign tgt_cyc = bus_valid && bus_write && bus_addr[3:2] == 2'd1;
    assign dat_cyc = bus_valid && bus_write && bus_addr[3:2] == 2'd2;

    a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        key_cyc && bus_wdata == DATA_W'(UNLOCK_KEY) |=> port_open);

    a_r3_bad_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
        key_cyc && bus_wdata != DATA_W'(UNLOCK_KEY) |=> !port_open);

    a_r4_target_load: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_cyc |=> tgt_addr == $past(bus_wdata[ADDR_W-1:0]));

    a_r5_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pm_wr_en |-> $past(dat_cyc) && $past(port_open));

    a_r6_closed_drops: assert property (@(posedge clk) disable iff (!rst_n)
        dat_cyc && !port_open |=> !pm_wr_en && $stable(tgt_addr));

    a_r7_step_four: assert property (@(posedge clk) disable iff (!rst_n)
        dat_cyc && port_open |=> tgt_addr == $past(tgt_addr) + ADDR_W'(4));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> !pm_wr_en && $stable(tgt_addr) && $stable(port_open));
endmodule

bind progmem_write_port progmem_write_port_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pm_wr_en  (pm_wr_en),
    .port_open (port_open),
    .tgt_addr  (tgt_addr)
);

// File: tb/test_progmem_write_port.sv
module test_progmem_write_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic        pm_wr_en;
    logic [29:0] pm_wr_addr;
    logic [31:0] pm_wr_data;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // Behavioural reference state
    bit          m_open = 0;
    bit [31:0]   m_tgt = 0;
    bit          e_en = 0;
    bit [29:0]   e_addr = 0;
    bit [31:0]   e_data = 0;

    always #10 clk = ~clk;

    progmem_write_port i_progmem_write_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .pm_wr_en   (pm_wr_en),
        .pm_wr_addr (pm_wr_addr),
        .pm_wr_data (pm_wr_data)
    );

    // Reference model: advance one clock from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_tgt = 0; e_en = 0;
        end else begin
            e_en = 0;
            if (bus_valid && bus_write) begin
                case (bus_addr[3:2])
                    2'd0: m_open = (bus_wdata == 32'h1337F7D1);
                    2'd1: m_tgt = bus_wdata;
                    2'd2: if (m_open) begin
                        e_en = 1; e_addr = m_tgt[31:2]; e_data = bus_wdata;
                        m_tgt = m_tgt + 32'd4;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        n_cmp++;
        if (pm_wr_en !== e_en) begin
            n_bad++;
            $display("FAIL %s pm_wr_en actual %0b expected %0b", cur_req, pm_wr_en, e_en);
        end else if (e_en) begin
            n_cmp++;
            if (pm_wr_addr !== e_addr || pm_wr_data !== e_data) begin
                n_bad++;
                $display("FAIL %s write actual %h/%h expected %h/%h",
                         cur_req, pm_wr_addr, pm_wr_data, e_addr, e_data);
            end
        end
    end

    task automatic cyc(input bit v, input bit w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1, 1, a, d);
    endtask

    task automatic idle();
        cyc(0, 0, 4'd0, 32'd0);
    endtask

    // Explicit strobe check for a specific expected word, one cycle after issue.
    task automatic expect_word(input string req, input logic [29:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        #1;
        n_cmp++;
        if (pm_wr_en !== 1'b1 || pm_wr_addr !== a || pm_wr_data !== d) begin
            n_bad++;
            $display("FAIL %s direct actual %b %h/%h expected 1 %h/%h",
                     req, pm_wr_en, pm_wr_addr, pm_wr_data, a, d);
        end
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R6";
        wr(4'h8, 32'hDEAD0001); idle();

        cur_req = "R2"; wr(4'h0, 32'h1337F7D1);
        cur_req = "R4"; wr(4'h4, 32'h0000_0100);
        cur_req = "R5"; wr(4'h8, 32'hA0A0_0001);
        expect_word("R5", 30'h40, 32'hA0A0_0001);
        cur_req = "R7"; wr(4'h8, 32'hA0A0_0002); wr(4'h8, 32'hA0A0_0003); idle();

        cur_req = "R3"; wr(4'h0, 32'h1337F7D0);
        cur_req = "R6"; wr(4'h8, 32'hBAD0_0001); idle();
        cur_req = "R3"; wr(4'h0, 32'h9337F7D1); wr(4'h8, 32'hBAD0_0002);
        cur_req = "R6"; wr(4'h0, 32'h1337F7D1); wr(4'h8, 32'hC0C0_0001);
        expect_word("R6", 30'h43, 32'hC0C0_0001);

        cur_req = "R7"; wr(4'h4, 32'hFFFF_FFFC); wr(4'h8, 32'h1111_1111); wr(4'h8, 32'h2222_2222);
        idle();
        cur_req = "R8"; wr(4'h4, 32'h0000_0203); wr(4'h8, 32'h3333_3333);
        expect_word("R8", 30'h80, 32'h3333_3333);
        wr(4'h8, 32'h4444_4444); idle();

        cur_req = "R9";
        cyc(0, 1, 4'h8, 32'h5555_0001);
        cyc(1, 0, 4'h8, 32'h5555_0002);
        cyc(1, 1, 4'hC, 32'h5555_0003);
        cyc(0, 1, 4'h0, 32'h0);
        cyc(1, 0, 4'h4, 32'h0);
        wr(4'h8, 32'h5555_0004);
        expect_word("R9", 30'h82, 32'h5555_0004);

        cur_req = "R10"; wr(4'hB, 32'h6666_0001); wr(4'h5, 32'h0000_1000);
        wr(4'h1, 32'h1337F7D1); wr(4'hA, 32'h6666_0002);
        expect_word("R10", 30'h400, 32'h6666_0002);

        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        wr(4'h8, 32'h7777_0001); idle();
        wr(4'h0, 32'h1337F7D1); wr(4'h8, 32'h7777_0002);
        expect_word("R1", 30'h0, 32'h7777_0002);

        cur_req = "R2 R3 R4 R5 R7 mix";
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [31:0] d;
            r = $urandom_range(0, 9);
            d = $urandom;
            case (r)
                0: wr(4'h0, 32'h1337F7D1);
                1: wr(4'h0, d);
                2: wr(4'h4, d);
                3, 4, 5, 6: wr({2'b10, 2'(d[1:0])}, d);
                7: cyc(1, 0, 4'(d[3:0]), d);
                8: wr(4'hC, d);
                default: idle();
            endcase
        end
        idle(); idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule